// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer with Input Capture

This block is one 16-bit timer channel behind a small register port. A two-bit source field picks the clock that feeds the count: the system clock, the system clock divided by sixteen, rising edges on the external timer pin, or a tick pulse supplied by a neighbouring channel. The chosen source goes through an 8-bit prescaler and then drives a 16-bit up-counter.

On every prescaled tick the counter is compared with a reference register. A match sets an event flag and drives the timer output pin. In restart mode the count then returns to zero; in free-run mode it keeps going and wraps. The external pin is synchronised and watched for edges. On the selected edge the present count is copied into a capture register and a capture flag is set. Both flags are cleared by writing a one to them. They feed a single level interrupt through their own enables. Software sets up the mode and reference, lets the channel run through the global control bits, and polls or takes interrupts.

Top module: `refcmp_timer`

## Requirements
- R1: After reset every register reads zero, and `irq_o` and `tout_o` are low.
- R2: While global-control bit 0 is clear, the counter and prescaler are held at zero and writes to the counter are ignored.
- R3: While bit 0 is set and either bit 1 (stop) or bit 2 (freeze) of global control is set, the counter holds its value. Counter writes still take effect.
- R4: Mode bits 15:8 hold P, and the count advances once every P+1 source ticks. With the system clock as source, the counter reads floor(n/(P+1)) n clock edges after the run bit is set.
- R5: Mode bits 2:1 select the source. 01 is the system clock and 10 is the system clock divided by 16 (first tick on the 16th edge after run). 11 is a synchronised rising edge of `tin_i`, and 00 is each cycle that `casc_tick_i` is high.
- R6: With mode bit 3 set (restart), a tick that finds the counter equal to the reference returns the counter to zero. Matches then recur every (R+1)(P+1) source ticks.
- R7: With mode bit 3 clear (free run), the counter passes the reference, wraps from 0xFFFF to 0, and still raises the match event.
- R8: Event register bit 1 is set on a reference match and bit 0 on a capture. Writing a 1 to a bit clears only that bit, and a new event in the same cycle wins over the clear.
- R9: Mode bits 7:6 pick the capture edge of `tin_i`: 00 none, 01 rising, 10 falling, 11 both. On that edge the count is copied into the capture register.
- R10: `irq_o` = (event bit 1 AND mode bit 4) OR (event bit 0 AND mode bits 7:6 not 00).
- R11: With mode bit 5 clear, `tout_o` is high for the single cycle after each match edge. With mode bit 5 set, it toggles at each match.
- R12: Register offsets are 0 global control (3 bits), 1 mode, 2 reference, 3 capture (read only), 4 counter and 5 events. Reads are combinational on `rd_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write offset |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read offset |
| rd_data_o | output | 16 | Register read data |
| casc_tick_i | input | 1 | Tick pulse from a neighbouring channel (source 00) |
| tin_i | input | 1 | External timer pin, asynchronous |
| irq_o | output | 1 | Level interrupt |
| tout_o | output | 1 | Timer output pin |

## Verification
A register write lands on the clock edge that samples it. Internal sources tick from the next edge onward, so with the system clock the counter changes on edge n when n is a multiple of P+1. The match flag and the output pin change on the same edge as the matching tick. A pin edge passes two synchroniser flops and an edge-detect flop, so the capture and any pin-sourced tick are due on the third edge after the pin changes. The bench drives inputs on falling edges, counts falling edges from the write edge, and samples half a nanosecond after a falling edge. Where the timing is not under test it waits five cycles before checking.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        SRC_CASC  = 2'b00,
        SRC_SYS   = 2'b01,
        SRC_DIV   = 2'b10,
        SRC_PIN   = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        CAP_OFF   = 2'b00,
        CAP_RISE  = 2'b01,
        CAP_FALL  = 2'b10,
        CAP_BOTH  = 2'b11
    } cap_mode_e;

    localparam logic [ADDR_W-1:0] A_GCTL = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] A_REF  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAPT = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_EVT  = 3'd5;

    typedef struct packed {
        logic [2:0]       gctl;
        logic [REG_W-1:0] mode;
        logic [CNT_W-1:0] refv;
        logic [CNT_W-1:0] capv;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       evt;
        logic             tout;
    } tmr_state_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int MSB = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin_i};
        st_d.prev  = st_q.chain[MSB];
        rise_o     = st_q.chain[MSB] & ~st_q.prev;
        fall_o     = ~st_q.chain[MSB] & st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    // R9
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
    parameter int DIV_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       en_i,
    input  logic [1:0] src_i,
    input  logic       casc_i,
    input  logic       pin_rise_i,
    output logic       src_tick_o
);
    import tmr_pkg::*;

    logic [DIV_W-1:0] div_d, div_q;
    logic             div_tick;

    always_comb begin
        div_d = div_q;
        if (clear_i)   div_d = '0;
        else if (en_i) div_d = div_q + 1'b1;
        div_tick = en_i & (&div_q);
        unique case (clk_src_e'(src_i))
            SRC_CASC: src_tick_o = en_i & casc_i;
            SRC_SYS:  src_tick_o = en_i;
            SRC_DIV:  src_tick_o = div_tick;
            SRC_PIN:  src_tick_o = en_i & pin_rise_i;
            default:  src_tick_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R5
    src_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_tick_o |-> en_i);
    // R5
    div_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_tick && !clear_i) |=> (div_q == '0));
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             src_tick_i,
    input  logic [PSC_W-1:0] limit_i,
    output logic             tick_o
);
    logic [PSC_W-1:0] pcnt_d, pcnt_q;

    always_comb begin
        tick_o = src_tick_i & (pcnt_q >= limit_i);
        pcnt_d = pcnt_q;
        if (clear_i)         pcnt_d = '0;
        else if (tick_o)     pcnt_d = '0;
        else if (src_tick_i) pcnt_d = pcnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    // R4
    psc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> src_tick_i);
    // R4
    psc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (pcnt_q == '0));
endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer #(
    parameter int PSC_W       = 8,
    parameter int DIV_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [2:0]  wr_addr_i,
    input  logic [15:0] wr_data_i,
    input  logic [2:0]  rd_addr_i,
    output logic [15:0] rd_data_o,
    input  logic        casc_tick_i,
    input  logic        tin_i,
    output logic        irq_o,
    output logic        tout_o
);
    import tmr_pkg::*;

    localparam int PSC_LSB = REG_W - PSC_W;

    tmr_state_t st_d, st_q;

    logic             run, cnt_en;
    logic             pin_rise, pin_fall;
    logic             src_tick, tick;
    logic             match, cap_hit;
    logic [1:0]       src_sel;
    cap_mode_e        cap_mode;
    logic             restart, ref_ie, tog_mode;
    logic [PSC_W-1:0] psc_val;

    assign run      = st_q.gctl[0];
    assign cnt_en   = run & ~st_q.gctl[1] & ~st_q.gctl[2];
    assign psc_val  = st_q.mode[REG_W-1:PSC_LSB];
    assign cap_mode = cap_mode_e'(st_q.mode[7:6]);
    assign tog_mode = st_q.mode[5];
    assign ref_ie   = st_q.mode[4];
    assign restart  = st_q.mode[3];
    assign src_sel  = st_q.mode[2:1];

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (tin_i),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    tmr_src_sel #(.DIV_W(DIV_W)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (~run),
        .en_i       (cnt_en),
        .src_i      (src_sel),
        .casc_i     (casc_tick_i),
        .pin_rise_i (pin_rise),
        .src_tick_o (src_tick)
    );

    tmr_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (~run),
        .src_tick_i (src_tick),
        .limit_i    (psc_val),
        .tick_o     (tick)
    );

    always_comb begin
        match   = tick & (st_q.cnt == st_q.refv);
        cap_hit = run & (((cap_mode == CAP_RISE || cap_mode == CAP_BOTH) && pin_rise) ||
                         ((cap_mode == CAP_FALL || cap_mode == CAP_BOTH) && pin_fall));

        st_d = st_q;

        if (wr_en_i) begin
            unique case (wr_addr_i)
                A_GCTL:  st_d.gctl = wr_data_i[2:0];
                A_MODE:  st_d.mode = wr_data_i;
                A_REF:   st_d.refv = wr_data_i;
                A_EVT:   st_d.evt  = st_q.evt & ~wr_data_i[1:0];
                default: ;
            endcase
        end

        if (!run)
            st_d.cnt = '0;
        else if (wr_en_i && wr_addr_i == A_CNT)
            st_d.cnt = wr_data_i;
        else if (tick)
            st_d.cnt = (match && restart) ? '0 : st_q.cnt + 1'b1;

        if (match) st_d.evt[1] = 1'b1;
        if (cap_hit) begin
            st_d.evt[0] = 1'b1;
            st_d.capv   = st_q.cnt;
        end

        st_d.tout = tog_mode ? (st_q.tout ^ match) : match;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (rd_addr_i)
            A_GCTL:  rd_data_o = {13'd0, st_q.gctl};
            A_MODE:  rd_data_o = st_q.mode;
            A_REF:   rd_data_o = st_q.refv;
            A_CAPT:  rd_data_o = st_q.capv;
            A_CNT:   rd_data_o = st_q.cnt;
            A_EVT:   rd_data_o = {14'd0, st_q.evt};
            default: rd_data_o = '0;
        endcase
    end

    assign irq_o  = (st_q.evt[1] & ref_ie) | (st_q.evt[0] & (cap_mode != CAP_OFF));
    assign tout_o = st_q.tout;

    // R2
    hold_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0));
    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_en && !(wr_en_i && wr_addr_i == A_CNT)) |=> $stable(st_q.cnt));
    // R6
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && restart && !(wr_en_i && wr_addr_i == A_CNT)) |=> (st_q.cnt == '0));
    // R8
    ref_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> st_q.evt[1]);
    // R8
    cap_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> st_q.evt[0]);
    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (st_q.evt != 2'b00));
    // R11
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_o && !tog_mode && !match) |=> !tout_o);
endmodule

// File: tb/tb_refcmp_timer.sv
`timescale 1ns/1ps
module tb_refcmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [2:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;
    logic        casc_tick_i = 1'b0;
    logic        tin_i = 1'b0;
    logic        irq_o, tout_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    refcmp_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .casc_tick_i(casc_tick_i), .tin_i(tin_i), .irq_o(irq_o), .tout_o(tout_o)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        rd_addr_i = a;
        #0.5;
        v = rd_data_o;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2, exp_cap;
        int n, m;

        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(a[2:0], v);
            check($sformatf("R1 reg%0d", a), v, 16'h0);
        end
        check("R1 irq", {15'd0, irq_o}, 16'h0);
        check("R1 tout", {15'd0, tout_o}, 16'h0);

        // R2 held in reset while run bit clear
        wr(1, 16'h0002);
        wr(4, 16'h0055);
        rd(4, v);
        check("R2 cnt write ignored", v, 16'h0);
        cycles(10);
        rd(4, v);
        check("R2 cnt held", v, 16'h0);

        // R4 prescaler sweep on system clock, free run
        for (int p = 0; p < 4; p++) begin
            wr(0, 16'h0);
            wr(1, (16'(p) << 8) | 16'h0002);
            wr(2, 16'hFFFF);
            rd_addr_i = 3'd4;
            wr(0, 16'h0001);
            for (int k = 0; k <= 12; k++) begin
                if (k > 0) @(negedge clk);
                rd(4, v);
                check($sformatf("R4 P=%0d n=%0d", p, k), v, 16'(k / (p + 1)));
            end
        end

        // R5 divided-by-16 source
        wr(0, 16'h0);
        wr(1, 16'h0004);
        rd_addr_i = 3'd4;
        wr(0, 16'h0001);
        for (int k = 0; k <= 40; k++) begin
            if (k > 0) @(negedge clk);
            rd(4, v);
            check($sformatf("R5 div16 n=%0d", k), v, 16'(k / 16));
        end

        // R5 external pin source
        wr(0, 16'h0);
        wr(1, 16'h0006);
        wr(0, 16'h0001);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); tin_i = 1'b1;
            cycles(3); tin_i = 1'b0;
            cycles(3);
        end
        cycles(4);
        rd(4, v);
        check("R5 pin ticks", v, 16'd3);

        // R5 cascade source
        wr(0, 16'h0);
        wr(1, 16'h0000);
        wr(0, 16'h0001);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); casc_tick_i = 1'b1;
            @(negedge clk); casc_tick_i = 1'b0;
            cycles(2);
        end
        rd(4, v);
        check("R5 cascade ticks", v, 16'd5);

        // R6 R11 restart period sweep, pulse output
        for (int p = 0; p < 3; p++) begin
            for (int r = 0; r < 4; r++) begin
                wr(0, 16'h0);
                wr(2, 16'(r));
                wr(1, (16'(p) << 8) | 16'h001A);
                wr(5, 16'h0003);
                wr(0, 16'h0001);
                n = 0;
                do begin @(negedge clk); n++; end while (!tout_o && n < 100);
                check($sformatf("R6 first P=%0d R=%0d", p, r), 16'(n), 16'((r + 1) * (p + 1)));
                m = 0;
                do begin @(negedge clk); m++; end while (!tout_o && m < 100);
                check($sformatf("R11 period P=%0d R=%0d", p, r), 16'(m), 16'((r + 1) * (p + 1)));
                #0.5;
                check("R10 ref irq enabled", {15'd0, irq_o}, 16'h1);
            end
        end

        // R11 toggle mode, R=1 P=0
        wr(0, 16'h0);
        wr(2, 16'h0001);
        wr(1, 16'h002A);
        wr(0, 16'h0001);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            #0.5;
            check($sformatf("R11 toggle n=%0d", k), {15'd0, tout_o}, 16'((k / 2) % 2));
        end

        // R7 free-run wrap
        wr(0, 16'h0);
        wr(1, 16'h0002);
        wr(2, 16'h0001);
        wr(0, 16'h0003);
        wr(4, 16'hFFFE);
        wr(5, 16'h0003);
        wr(0, 16'h0001);
        cycles(3);
        rd(4, v); rd(5, v2);
        check("R7 wrap count", v, 16'h0001);
        check("R7 no event yet", v2, 16'h0000);
        @(negedge clk);
        rd(4, v); rd(5, v2);
        check("R7 passes ref", v, 16'h0002);
        check("R7 event set", v2, 16'h0002);
        check("R10 ref irq masked", {15'd0, irq_o}, 16'h0);

        // R3 stop and freeze
        wr(0, 16'h0003);
        rd(4, v);
        cycles(10);
        rd(4, v2);
        check("R3 stop holds", v2, v);
        wr(4, 16'h0123);
        rd(4, v);
        check("R3 write while stopped", v, 16'h0123);
        wr(0, 16'h0005);
        cycles(10);
        rd(4, v);
        check("R3 freeze holds", v, 16'h0123);

        // R8 write-one-to-clear and set-wins
        wr(0, 16'h0);
        wr(2, 16'h0000);
        wr(1, 16'h004A);
        wr(5, 16'h0003);
        wr(0, 16'h0001);
        wr(5, 16'h0002);
        rd(5, v);
        check("R8 set wins over clear", v, 16'h0002);
        wr(0, 16'h0003);
        @(negedge clk); tin_i = 1'b1;
        cycles(5);
        rd(5, v);
        check("R8 both events", v, 16'h0003);
        wr(5, 16'h0002);
        rd(5, v);
        check("R8 clear ref only", v, 16'h0001);
        wr(5, 16'h0001);
        rd(5, v);
        check("R8 clear cap", v, 16'h0000);
        rd(3, exp_cap);
        check("R9 rising capture value", exp_cap, 16'h0000);
        @(negedge clk); tin_i = 1'b0;
        cycles(5);

        // R9 R10 capture-mode sweep on a halted counter
        for (int cm = 0; cm < 4; cm++) begin
            wr(0, 16'h0);
            wr(1, (16'(cm) << 6) | 16'h0002);
            wr(0, 16'h0003);
            wr(4, 16'h1000 + 16'(cm));
            wr(5, 16'h0003);
            @(negedge clk); tin_i = 1'b1;
            cycles(5);
            if (cm == 1 || cm == 3) exp_cap = 16'h1000 + 16'(cm);
            rd(3, v);
            check($sformatf("R9 rise mode=%0d cap", cm), v, exp_cap);
            rd(5, v);
            check($sformatf("R9 rise mode=%0d evt", cm), v, (cm == 1 || cm == 3) ? 16'h1 : 16'h0);
            check($sformatf("R10 rise mode=%0d irq", cm), {15'd0, irq_o},
                  (cm == 1 || cm == 3) ? 16'h1 : 16'h0);
            wr(5, 16'h0003);
            wr(4, 16'h2000 + 16'(cm));
            @(negedge clk); tin_i = 1'b0;
            cycles(5);
            if (cm == 2 || cm == 3) exp_cap = 16'h2000 + 16'(cm);
            rd(3, v);
            check($sformatf("R9 fall mode=%0d cap", cm), v, exp_cap);
            rd(5, v);
            check($sformatf("R9 fall mode=%0d evt", cm), v, (cm == 2 || cm == 3) ? 16'h1 : 16'h0);
        end

        // R12 register map readback
        wr(2, 16'hA5C3);
        wr(1, 16'h3C02);
        rd(2, v);
        check("R12 ref readback", v, 16'hA5C3);
        rd(1, v);
        check("R12 mode readback", v, 16'h3C02);
        rd(0, v);
        check("R12 gctl readback", v, 16'h0003);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule